// File: doc/BRIEF.md
# Masked Four-Lane Vector Execution Unit

This block runs element-wise integer operations on a private vector register file. The file has eight registers of 64 elements, each element 64 bits wide. Element `i` of every register is stored in lane `i mod 4`. Each lane keeps its own quarter of each register, together with an adder, a subtractor and a low-half multiplier. One element group, meaning one element from each lane, is processed per cycle. Lanes never exchange operand data.

A single command port drives the block. It carries an opcode, a destination index, two source indices, a 64-bit scalar and an element index, all qualified by `start`. A command is taken only while `busy` is low. Completion is marked by a one-cycle `done` pulse. The block also holds an active-length register and a per-element write-enable mask. Both are visible on output ports. Any element can be read combinationally through a read port.

Top module: `vec_lane_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0, `vl_out` is 64 and every bit of `mask_out` is 1.
- R2: Opcode 0 writes `vs1[i] + vs2[i]` to `vd[i]` and opcode 1 writes `vs1[i] - vs2[i]`, both modulo 2^64, for every element `i` below the active length.
- R3: Opcode 2 writes the low 64 bits of `vs1[i] * scalar` to `vd[i]` for every element `i` below the active length.
- R4: Opcode 5 sets the active length to `scalar`, saturated at 64. The new value appears on `vl_out` the cycle after the command is accepted.
- R5: A vector command (opcodes 0 to 3) with active length L > 0 keeps `busy` high for ceil(L/4) cycles, starting the cycle after acceptance. `done` is high for exactly the one cycle after `busy` falls, so L = 64 takes 16 busy cycles.
- R6: With active length 0, a vector command raises `done` the cycle after acceptance. In that case `busy` stays low and no register or mask bit changes.
- R7: A destination element whose mask bit is 0 keeps its old value. So does any element at or above the active length.
- R8: The number of busy cycles of a vector command does not depend on the mask contents.
- R9: Opcode 3 sets mask bit `i` to `(vs1[i] != scalar)` for each `i` below the active length. Mask bits at or above the active length are unchanged, and no register is written.
- R10: Opcode 4 sets all 64 mask bits to 1, and `done` follows one cycle after acceptance.
- R11: Opcode 6 writes `scalar` into element `elem_idx` of register `vd` regardless of mask or length. `done` follows one cycle after acceptance.
- R12: A `start` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command valid; accepted when `busy` is low |
| opcode | input | 3 | 0 add, 1 sub, 2 scalar multiply, 3 compare-not-equal, 4 mask set-all, 5 set length, 6 element write |
| vd | input | 3 | Destination register index |
| vs1 | input | 3 | First source register index |
| vs2 | input | 3 | Second source register index |
| scalar | input | 64 | Scalar operand, length value or element write data |
| elem_idx | input | 6 | Element index for opcode 6 |
| busy | output | 1 | Element groups are being processed |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | 7 | Current active length |
| mask_out | output | 64 | Current write-enable mask, bit i for element i |
| rd_reg | input | 3 | Read port register index |
| rd_idx | input | 6 | Read port element index |
| rd_data | output | 64 | Combinational element read data |

## Verification
A wrong group counter or a wrong length decode shows up at once in the `busy` and `done` waveform, which is compared with the model on every cycle. A lane that writes the wrong bank slot, ignores its mask bit or runs past the active length leaves corrupted data in the register file. That corruption appears at `rd_data` in the full-file sweep that follows each command. A wrong compare lane shows on `mask_out` as soon as the command completes.

// File: rtl/vec_lane_unit.sv
module vec_lane_unit #(
  parameter int NREG  = 8,
  parameter int VLMAX = 64,
  parameter int W     = 64,
  parameter int LANES = 4,
  parameter int RW    = $clog2(NREG),
  parameter int EW    = $clog2(VLMAX),
  parameter int VW    = EW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    opcode,
  input  logic [RW-1:0] vd,
  input  logic [RW-1:0] vs1,
  input  logic [RW-1:0] vs2,
  input  logic [W-1:0]  scalar,
  input  logic [EW-1:0] elem_idx,
  output logic          busy,
  output logic          done,
  output logic [VW-1:0] vl_out,
  output logic [VLMAX-1:0] mask_out,
  input  logic [RW-1:0] rd_reg,
  input  logic [EW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  localparam int LW    = $clog2(LANES);
  localparam int GW    = EW - LW;
  localparam int DEPTH = NREG * (VLMAX / LANES);
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_MUL = 3'd2, OP_CMP = 3'd3,
                         OP_SET = 3'd4, OP_LEN = 3'd5, OP_WEL = 3'd6;

  logic          busy_q, done_q;
  logic [GW-1:0] grp_q;
  logic [VW-1:0] vl_q;
  logic [VLMAX-1:0] mask_q;
  logic [2:0]    op_q;
  logic [RW-1:0] vd_q, vs1_q, vs2_q;
  logic [W-1:0]  scal_q;
  logic [LANES-1:0] cmp_ne, lane_act;
  logic [W-1:0]  lane_rd [LANES];

  wire accept = start & ~busy_q;
  wire is_vec = (opcode <= OP_CMP);
  wire is_arith = (op_q == OP_ADD) || (op_q == OP_SUB) || (op_q == OP_MUL);
  wire [GW-1:0] last_grp = GW'((vl_q - VW'(1)) >> LW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      grp_q  <= '0;
      vl_q   <= VW'(VLMAX);
      op_q   <= OP_ADD;
      vd_q   <= '0;
      vs1_q  <= '0;
      vs2_q  <= '0;
      scal_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (grp_q == last_grp) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          grp_q <= grp_q + GW'(1);
        end
      end else if (accept) begin
        op_q   <= opcode;
        vd_q   <= vd;
        vs1_q  <= vs1;
        vs2_q  <= vs2;
        scal_q <= scalar;
        grp_q  <= '0;
        if (is_vec && vl_q != '0) busy_q <= 1'b1;
        else done_q <= 1'b1;
        if (opcode == OP_LEN)
          vl_q <= (scalar > W'(VLMAX)) ? VW'(VLMAX) : VW'(scalar);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (accept && opcode == OP_SET) begin
      mask_q <= '1;
    end else if (op_q == OP_CMP) begin
      for (int l = 0; l < LANES; l++)
        if (lane_act[l]) mask_q[{grp_q, LW'(l)}] <= cmp_ne[l];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [LW-1:0] LID = LW'(l);
    logic [W-1:0] bank [DEPTH];
    logic [W-1:0] a, b, res;
    logic [EW-1:0] e;
    logic wr_vec, wr_one;

    assign e = {grp_q, LID};
    assign a = bank[{vs1_q, grp_q}];
    assign b = bank[{vs2_q, grp_q}];
    assign lane_act[l] = busy_q && ({1'b0, e} < vl_q);
    assign cmp_ne[l]   = (a != scal_q);

    always_comb begin
      case (op_q)
        OP_ADD:  res = a + b;
        OP_SUB:  res = a - b;
        OP_MUL:  res = a * scal_q;
        default: res = a;
      endcase
    end

    assign wr_vec = lane_act[l] && mask_q[e] && is_arith;
    assign wr_one = accept && (opcode == OP_WEL) && (elem_idx[LW-1:0] == LID);

    always_ff @(posedge clk) begin
      if (wr_vec) bank[{vd_q, grp_q}] <= res;
      else if (wr_one) bank[{vd, elem_idx[EW-1:LW]}] <= scalar;
    end

    assign lane_rd[l] = bank[{rd_reg, rd_idx[EW-1:LW]}];
  end

  assign rd_data  = lane_rd[rd_idx[LW-1:0]];
  assign busy     = busy_q;
  assign done     = done_q;
  assign vl_out   = vl_q;
  assign mask_out = mask_q;
endmodule

// File: rtl/vec_lane_unit_chk.sv
module vec_lane_unit_chk #(
  parameter int VLMAX = 64,
  parameter int VW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2:0]       opcode,
  input logic             busy,
  input logic             done,
  input logic [VW-1:0]    vl_out,
  input logic [VLMAX-1:0] mask_out
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  // R4
  vl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) vl_out <= VW'(VLMAX));
  // R10
  mask_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && opcode == 3'd4) |=> (mask_out == '1));
  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && opcode == 3'd5) |=> $stable(vl_out));
  // R6
  empty_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && opcode <= 3'd3 && vl_out == '0) |=> (done && !busy && $stable(mask_out)));
endmodule

bind vec_lane_unit vec_lane_unit_chk #(.VLMAX(VLMAX), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
  .busy(busy), .done(done), .vl_out(vl_out), .mask_out(mask_out)
);

// File: tb/sim_vec_lane_unit.sv
`timescale 1ns/1ps
module sim_vec_lane_unit;
  localparam real HALF = 10.0;
  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] opcode = 0, vd = 0, vs1 = 0, vs2 = 0, rd_reg = 0;
  logic [63:0] scalar = 0;
  logic [5:0] elem_idx = 0, rd_idx = 0;
  logic busy, done;
  logic [6:0] vl_out;
  logic [63:0] mask_out, rd_data;

  vec_lane_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .vd(vd),
    .vs1(vs1), .vs2(vs2), .scalar(scalar), .elem_idx(elem_idx), .busy(busy), .done(done),
    .vl_out(vl_out), .mask_out(mask_out), .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data));

  always #(HALF) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [63:0] mreg [8][64];
  logic [63:0] mmask;
  int mvl, mcnt;
  bit m_busy, m_done;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_exec();
    case (opcode)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        for (int i = 0; i < mvl; i++) begin
          if (opcode == 3'd3) mmask[i] = (mreg[vs1][i] != scalar);
          else if (mmask[i]) begin
            if (opcode == 3'd0) mreg[vd][i] = mreg[vs1][i] + mreg[vs2][i];
            else if (opcode == 3'd1) mreg[vd][i] = mreg[vs1][i] - mreg[vs2][i];
            else mreg[vd][i] = mreg[vs1][i] * scalar;
          end
        end
        mcnt = (mvl + 3) / 4;
        if (mcnt == 0) m_done = 1; else m_busy = 1;
      end
      3'd4: begin mmask = '1; m_done = 1; end
      3'd5: begin mvl = (scalar > 64) ? 64 : int'(scalar); m_done = 1; end
      3'd6: begin mreg[vd][elem_idx] = scalar; m_done = 1; end
      default: m_done = 1;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; mvl = 64; mmask = '1; mcnt = 0;
    end else if (m_busy) begin
      mcnt--;
      if (mcnt == 0) begin m_busy = 0; m_done = 1; end
    end else begin
      m_done = 0;
      if (start) model_exec();
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy === m_busy, "R5 busy", 64'(busy), 64'(m_busy));
      chk(done === m_done, "R5 done", 64'(done), 64'(m_done));
      chk(vl_out === 7'(mvl), "R4 length", 64'(vl_out), 64'(mvl));
      if (!m_busy) chk(mask_out === mmask, "R9 mask", mask_out, mmask);
    end
  end

  task automatic issue(input logic [2:0] op, input logic [2:0] d, input logic [2:0] s1,
                       input logic [2:0] s2, input logic [63:0] sc, input logic [5:0] ix,
                       output int bc);
    @(negedge clk);
    opcode = op; vd = d; vs1 = s1; vs2 = s2; scalar = sc; elem_idx = ix; start = 1;
    @(negedge clk);
    start = 0; bc = 0;
    while (!done) begin
      if (busy) bc++;
      @(negedge clk);
    end
  endtask

  task automatic sweep(input string req);
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++) begin
        rd_reg = 3'(r); rd_idx = 6'(i);
        #1;
        chk(rd_data === mreg[r][i], req, rd_data, mreg[r][i]);
      end
  endtask

  function automatic logic [63:0] pat(int r, int i);
    return (64'h9E3779B97F4A7C15 * 64'(r * 64 + i + 1)) ^ 64'((r << 8) | i);
  endfunction

  localparam logic [63:0] KEY = 64'hDEAD_BEEF_0123_4567;

  task automatic finish_sim();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_sim();
  end

  initial begin
    int bc;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 0, "R1 busy", 64'(busy), 0);
    chk(done === 0, "R1 done", 64'(done), 0);
    chk(vl_out === 7'd64, "R1 length", 64'(vl_out), 64);
    chk(mask_out === '1, "R1 mask", mask_out, '1);

    // R11 element writes fill the file
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++) begin
        v = pat(r, i);
        if (r == 1 && i == 3) v = KEY;
        if (r == 2 && (i == 7 || i == 20 || i == 33)) v = 0;
        issue(3'd6, 3'(r), 0, 0, v, 6'(i), bc);
      end
    sweep("R11 element write");

    issue(3'd0, 3, 1, 2, 0, 0, bc);
    chk(bc == 16, "R5 full length groups", 64'(bc), 16);
    sweep("R2 add");
    issue(3'd1, 4, 2, 1, 0, 0, bc);
    sweep("R2 sub");
    issue(3'd2, 5, 1, 0, 64'hF00D_0000_1234_5679, 0, bc);
    sweep("R3 multiply");

    issue(3'd5, 0, 0, 0, 200, 0, bc);
    chk(vl_out === 7'd64, "R4 saturate", 64'(vl_out), 64);
    issue(3'd5, 0, 0, 0, 5, 0, bc);
    chk(vl_out === 7'd5, "R4 set", 64'(vl_out), 5);
    issue(3'd0, 6, 1, 1, 0, 0, bc);
    chk(bc == 2, "R5 short length groups", 64'(bc), 2);
    sweep("R7 beyond length");

    issue(3'd5, 0, 0, 0, 10, 0, bc);
    issue(3'd3, 0, 1, 0, KEY, 0, bc);
    chk(mask_out === ~64'h8, "R9 compare with length", mask_out, ~64'h8);
    issue(3'd1, 7, 7, 2, 0, 0, bc);
    sweep("R7 masked element");

    issue(3'd5, 0, 0, 0, 64, 0, bc);
    issue(3'd3, 0, 2, 0, 0, 0, bc);
    v = ~((64'd1 << 7) | (64'd1 << 20) | (64'd1 << 33));
    chk(mask_out === v, "R9 compare full", mask_out, v);
    issue(3'd0, 3, 3, 1, 0, 0, bc);
    chk(bc == 16, "R8 masked groups", 64'(bc), 16);
    sweep("R7 masked add");

    issue(3'd4, 0, 0, 0, 0, 0, bc);
    chk(mask_out === '1, "R10 mask fill", mask_out, '1);

    issue(3'd5, 0, 0, 0, 0, 0, bc);
    issue(3'd0, 0, 1, 2, 0, 0, bc);
    chk(bc == 0, "R6 no busy", 64'(bc), 0);
    issue(3'd3, 0, 1, 0, KEY, 0, bc);
    chk(mask_out === '1, "R6 mask kept", mask_out, '1);
    sweep("R6 no writes");

    issue(3'd5, 0, 0, 0, 64, 0, bc);
    @(negedge clk);
    opcode = 3'd0; vd = 2; vs1 = 2; vs2 = 1; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); @(negedge clk);
    opcode = 3'd5; scalar = 3; start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    chk(vl_out === 7'd64, "R12 ignored start", 64'(vl_out), 64);
    sweep("R12 operation intact");

    repeat (2) @(negedge clk);
    finish_sim();
  end
endmodule